// File: doc/BRIEF.md
# Key-Sequenced 64-bit Watchdog Timer

This block is a bus-mapped watchdog. A 64-bit up-counter is compared against a 64-bit period. Software arms the counter with a two-step key handshake written to the watchdog control word, and keeps it alive with a second two-step handshake. The block pulses a system reset output for one cycle when the counter reaches the period. It raises the same pulse at once when a wrong key arrives while the watchdog is armed.

Before arming, software loads the period and counter words and selects the watchdog mode in the global and timer control words. From the first key onward the configuration is frozen. Only a hardware reset returns the block to idle. Reads are combinational: `busRdData` shows the addressed word while `busRdEn` is high, and is zero otherwise.

Top module: `key_watchdog`

## Requirements
- R1: After reset the block is idle and holds these values: the watchdog control word reads 0, both counter words and both period words read 0, the identification word (offset 0x00) reads the `ID_VALUE` parameter, and `sysResetOut` is low.
- R2: In idle, a write updates the addressed word. The byte offsets are 0x10 and 0x14 for the counter low and high words, 0x18 and 0x1C for the period low and high words, 0x20 for timer control (bits [7:6]), 0x24 for global control (bits [3:0]) and 0x04 for a scratch word. Each of these reads back what was written, and the scratch word has no effect on the block.
- R3: In the watchdog control word at offset 0x28, bits [31:16] are the key, bit 14 is enable and bit 15 is the timeout flag. Writing key 0xA5C6 with enable set moves idle to pre-active. A following write of key 0xDA7E with enable set moves the block to active. Bit 14 reads 1 from pre-active onward. In idle, any other key, or 0xA5C6 without enable, is ignored.
- R4: From pre-active onward, writes to the counter, period, timer control and global control words are ignored. The scratch word stays writable.
- R5: The counter advances by one per cycle only when the block is active, global control reads 0xB (mode 2 in bits [3:2], with bits 1 and 0 set), timer control bits [7:6] equal 2, and the flag is clear. Otherwise the counter holds its value.
- R6: When the counter equals the period while it is running, the flag (bit 15) is set and `sysResetOut` is high for one cycle. With the counter starting at 0, this pulse follows exactly P+1 clock edges after the edge that accepts the activating write, where P is the period. The counter then holds and the flag stays set.
- R7: The counter is a full 64-bit count. It carries from the low word into the high word, and the timeout compares all 64 bits.
- R8: While active, key 0xA5C6 enters a service state. Key 0xDA7E written in the service state clears the counter to 0 and returns the block to active.
- R9: In pre-active, active or service, a write to the watchdog control word whose key is not the next expected one gives a one-cycle `sysResetOut` pulse at once. In pre-active, the expected key also needs enable set. The state and the flag are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the word accessed |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Read data of the addressed word, zero when not reading |
| sysResetOut | output | 1 | One-cycle system reset pulse |

## Verification
The timeout path is run with several configurations, and each one separates a different fault:
- A small period starting from zero pins the exact cycle of the reset pulse.
- A counter preloaded just below a 32-bit boundary, with a nonzero high period word, exposes a missing carry or a compare that sees only the low word.
- A global control word with the wrong mode shows whether the counter runs without a valid configuration.

Key handling is tried in several ways:
- A service handshake halfway through the period.
- Wrong keys in pre-active and in active.
- Wrong or enable-less keys in idle.

Together these separate an acted-on key, an ignored key and a reset-causing key. Writes issued after arming check the lock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_W  = 16;

  localparam logic [7:0] OFS_IDENT  = 8'h00;
  localparam logic [7:0] OFS_SCRATCH = 8'h04;
  localparam logic [7:0] OFS_CNT_LO = 8'h10;
  localparam logic [7:0] OFS_CNT_HI = 8'h14;
  localparam logic [7:0] OFS_PRD_LO = 8'h18;
  localparam logic [7:0] OFS_PRD_HI = 8'h1C;
  localparam logic [7:0] OFS_TMR    = 8'h20;
  localparam logic [7:0] OFS_GLB    = 8'h24;
  localparam logic [7:0] OFS_WDOG   = 8'h28;

  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E;

  localparam int BIT_ENABLE = 14;
  localparam int BIT_FLAG   = 15;

  localparam logic [1:0] TMR_MODE_PERIODIC = 2'd2;
  localparam logic [3:0] GLB_WATCHDOG_RUN  = 4'hB;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_PREARM  = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_SERVICE = 2'd3
  } wdState_t;

  typedef struct packed {
    logic loadCntLo;
    logic loadCntHi;
    logic loadPrdLo;
    logic loadPrdHi;
    logic loadTmr;
    logic loadGlb;
    logic loadScratch;
    logic clearCnt;
    logic advance;
  } dpStrobe_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              hitPeriod,
  input  logic              cfgReady,
  output dpStrobe_t         strobe,
  output logic              armed,
  output logic              flag,
  output logic              sysReset
);
  localparam logic [ADDR_W-1:0] A_WDOG = ADDR_W'(OFS_WDOG);

  wdState_t state, stateNext;
  logic [KEY_W-1:0] key;
  logic enBit, wdHit, badKey, clearReq, running, timeoutEv, isIdle;

  assign key    = wrData[WORD_W-1 -: KEY_W];
  assign enBit  = wrData[BIT_ENABLE];
  assign wdHit  = wrEn && (addr == A_WDOG);
  assign isIdle = (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    badKey    = 1'b0;
    clearReq  = 1'b0;
    if (wdHit) begin
      unique case (state)
        ST_IDLE: if (key == KEY_FIRST && enBit) stateNext = ST_PREARM;
        ST_PREARM: begin
          if (key == KEY_SECOND && enBit) stateNext = ST_ACTIVE;
          else badKey = 1'b1;
        end
        ST_ACTIVE: begin
          if (key == KEY_FIRST) stateNext = ST_SERVICE;
          else badKey = 1'b1;
        end
        ST_SERVICE: begin
          if (key == KEY_SECOND) begin
            stateNext = ST_ACTIVE;
            clearReq  = 1'b1;
          end else badKey = 1'b1;
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  assign running   = (state == ST_ACTIVE || state == ST_SERVICE) && cfgReady && !flag;
  assign timeoutEv = running && hitPeriod;

  always_comb begin
    strobe.loadCntLo   = wrEn && isIdle && addr == ADDR_W'(OFS_CNT_LO);
    strobe.loadCntHi   = wrEn && isIdle && addr == ADDR_W'(OFS_CNT_HI);
    strobe.loadPrdLo   = wrEn && isIdle && addr == ADDR_W'(OFS_PRD_LO);
    strobe.loadPrdHi   = wrEn && isIdle && addr == ADDR_W'(OFS_PRD_HI);
    strobe.loadTmr     = wrEn && isIdle && addr == ADDR_W'(OFS_TMR);
    strobe.loadGlb     = wrEn && isIdle && addr == ADDR_W'(OFS_GLB);
    strobe.loadScratch = wrEn && addr == ADDR_W'(OFS_SCRATCH);
    strobe.clearCnt    = clearReq;
    strobe.advance     = running && !hitPeriod;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      flag     <= 1'b0;
      sysReset <= 1'b0;
    end else begin
      state    <= stateNext;
      flag     <= flag | timeoutEv;
      sysReset <= timeoutEv | badKey;
    end
  end

  assign armed = !isIdle;
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [WORD_W-1:0] ID_VALUE = 32'h5744_0001
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [WORD_W-1:0]   wrData,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                armed,
  input  logic                flag,
  output logic [WORD_W-1:0]   rdData,
  output logic                hitPeriod,
  output logic                cfgReady,
  output logic [2*WORD_W-1:0] count
);
  localparam int CNT_W = 2 * WORD_W;

  logic [CNT_W-1:0]  period;
  logic [1:0]        tmrMode;
  logic [3:0]        glbBits;
  logic [WORD_W-1:0] scratch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      period  <= '0;
      tmrMode <= '0;
      glbBits <= '0;
      scratch <= '0;
    end else begin
      if (strobe.clearCnt)       count <= '0;
      else if (strobe.loadCntLo) count[WORD_W-1:0] <= wrData;
      else if (strobe.loadCntHi) count[CNT_W-1:WORD_W] <= wrData;
      else if (strobe.advance)   count <= count + CNT_W'(1);
      if (strobe.loadPrdLo)   period[WORD_W-1:0] <= wrData;
      if (strobe.loadPrdHi)   period[CNT_W-1:WORD_W] <= wrData;
      if (strobe.loadTmr)     tmrMode <= wrData[7:6];
      if (strobe.loadGlb)     glbBits <= wrData[3:0];
      if (strobe.loadScratch) scratch <= wrData;
    end
  end

  assign hitPeriod = (count == period);
  assign cfgReady  = (glbBits == GLB_WATCHDOG_RUN) && (tmrMode == TMR_MODE_PERIODIC);

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        ADDR_W'(OFS_IDENT):   rdData = ID_VALUE;
        ADDR_W'(OFS_SCRATCH): rdData = scratch;
        ADDR_W'(OFS_CNT_LO):  rdData = count[WORD_W-1:0];
        ADDR_W'(OFS_CNT_HI):  rdData = count[CNT_W-1:WORD_W];
        ADDR_W'(OFS_PRD_LO):  rdData = period[WORD_W-1:0];
        ADDR_W'(OFS_PRD_HI):  rdData = period[CNT_W-1:WORD_W];
        ADDR_W'(OFS_TMR):     rdData = WORD_W'({tmrMode, 6'b0});
        ADDR_W'(OFS_GLB):     rdData = WORD_W'(glbBits);
        ADDR_W'(OFS_WDOG): begin
          rdData[BIT_ENABLE] = armed;
          rdData[BIT_FLAG]   = flag;
        end
        default: rdData = '0;
      endcase
    end
  end
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import wdt_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [WORD_W-1:0] ID_VALUE = 32'h5744_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  input  logic              busRdEn,
  output logic [31:0]       busRdData,
  output logic              sysResetOut
);
  dpStrobe_t           strobe;
  logic                armed, flag, hitPeriod, cfgReady;
  logic [2*WORD_W-1:0] count;

  wdt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr), .wrData(busWrData),
    .hitPeriod(hitPeriod), .cfgReady(cfgReady), .strobe(strobe),
    .armed(armed), .flag(flag), .sysReset(sysResetOut)
  );

  wdt_datapath #(.ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWrData),
    .rdEn(busRdEn), .addr(busAddr), .armed(armed), .flag(flag),
    .rdData(busRdData), .hitPeriod(hitPeriod), .cfgReady(cfgReady), .count(count)
  );
endmodule

// File: rtl/key_watchdog_chk.sv
module key_watchdog_chk
  import wdt_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                armed,
  input logic                flag,
  input logic                sysResetOut,
  input dpStrobe_t           strobe,
  input logic [2*WORD_W-1:0] count
);
  assert_armed_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> armed);

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    flag |=> flag);

  assert_flag_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> sysResetOut);

  assert_pulse_needs_arm_R9: assert property (@(posedge clk) disable iff (!rstN)
    sysResetOut |-> $past(armed));

  assert_count_holds_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.clearCnt && !strobe.loadCntLo && !strobe.loadCntHi)
      |=> $stable(count));

  assert_locked_loads_R4: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> !(strobe.loadPrdLo || strobe.loadPrdHi || strobe.loadTmr || strobe.loadGlb));
endmodule

bind key_watchdog key_watchdog_chk u_chk (
  .clk(clk), .rstN(rstN), .armed(armed), .flag(flag),
  .sysResetOut(sysResetOut), .strobe(strobe), .count(count)
);

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
  localparam logic [31:0] ID_EXP = 32'h5744_0001;
  localparam logic [31:0] ARM1   = 32'hA5C6_4000;
  localparam logic [31:0] ARM2   = 32'hDA7E_4000;
  localparam logic [31:0] SVC1   = 32'hA5C6_0000;
  localparam logic [31:0] SVC2   = 32'hDA7E_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic        busRdEn = 1'b0;
  logic [31:0] busRdData;
  logic        sysResetOut;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int pulseCount = 0;
  int lastPulseCyc = 0;
  int armCyc = 0;

  always #2.5 clk = ~clk;

  key_watchdog dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdEn(busRdEn), .busRdData(busRdData),
    .sysResetOut(sysResetOut)
  );

  always @(posedge clk) begin
    if (rstN && sysResetOut) begin
      pulseCount   <= pulseCount + 1;
      lastPulseCyc <= cyc;
    end
    cyc <= cyc + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    armCyc = cyc;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    busRdEn = 1'b0;
  endtask

  task automatic configure(input logic [31:0] glb, input logic [31:0] prdLo,
                           input logic [31:0] prdHi, input logic [31:0] cntLo);
    wr(8'h24, glb);
    wr(8'h20, 32'h80);
    wr(8'h18, prdLo);
    wr(8'h1C, prdHi);
    wr(8'h10, cntLo);
    wr(8'h14, 32'h0);
  endtask

  task automatic waitPulse(input int base, input int limit);
    for (int i = 0; i < limit && pulseCount == base; i++) @(negedge clk);
  endtask

  task automatic testResetState();
    logic [31:0] v;
    doReset();
    rd(8'h00, v); check("R1 ident", v, ID_EXP);
    rd(8'h28, v); check("R1 wdog ctrl", v, 0);
    rd(8'h10, v); check("R1 count lo", v, 0);
    rd(8'h1C, v); check("R1 period hi", v, 0);
    check("R1 reset out", sysResetOut, 0);
  endtask

  task automatic testIdleWrites();
    logic [31:0] v, v2;
    doReset();
    wr(8'h18, 32'h1234_5678); rd(8'h18, v); check("R2 period lo", v, 32'h1234_5678);
    wr(8'h14, 32'h0000_00AB); rd(8'h14, v); check("R2 count hi", v, 32'hAB);
    wr(8'h04, 32'hCAFE_F00D); rd(8'h04, v); check("R2 scratch", v, 32'hCAFE_F00D);
    wr(8'h24, 32'hB);         rd(8'h24, v); check("R2 global", v, 32'hB);
    wr(8'h20, 32'h80);        rd(8'h20, v); check("R2 timer ctrl", v, 32'h80);
    rd(8'h10, v); repeat (5) @(negedge clk); rd(8'h10, v2);
    check("R5 idle no count", v2, v);
  endtask

  task automatic testIdleKeys();
    logic [31:0] v;
    int base;
    doReset();
    base = pulseCount;
    wr(8'h28, 32'h1234_4000); rd(8'h28, v); check("R3 idle bad key ignored", v, 0);
    wr(8'h28, SVC1);          rd(8'h28, v); check("R3 first key without enable", v, 0);
    wr(8'h28, ARM2);          rd(8'h28, v); check("R3 second key in idle", v, 0);
    repeat (2) @(negedge clk);
    check("R3 idle no pulse", pulseCount - base, 0);
  endtask

  task automatic testTimeoutExact();
    logic [31:0] v;
    int base, delta;
    doReset();
    configure(32'hB, 32'd40, 32'd0, 32'd0);
    base = pulseCount;
    wr(8'h28, ARM1);
    rd(8'h28, v); check("R3 prearm enable bit", v, 32'h4000);
    wr(8'h28, ARM2);
    delta = armCyc;
    wr(8'h18, 32'd5); rd(8'h18, v); check("R4 period locked", v, 32'd40);
    wr(8'h04, 32'h55); rd(8'h04, v); check("R4 scratch writable", v, 32'h55);
    waitPulse(base, 200);
    repeat (4) @(negedge clk);
    check("R6 one pulse", pulseCount - base, 1);
    check("R6 pulse cycle", lastPulseCyc - delta, 42);
    rd(8'h28, v); check("R6 flag set", v, 32'hC000);
    rd(8'h10, v); check("R6 count holds", v, 32'd40);
  endtask

  task automatic testCarry();
    logic [31:0] v;
    int base;
    doReset();
    configure(32'hB, 32'h10, 32'h1, 32'hFFFF_FFF0);
    base = pulseCount;
    wr(8'h28, ARM1); wr(8'h28, ARM2);
    waitPulse(base, 200);
    repeat (2) @(negedge clk);
    check("R7 pulse after carry", pulseCount - base, 1);
    rd(8'h14, v); check("R7 count hi", v, 1);
    rd(8'h10, v); check("R7 count lo", v, 32'h10);
  endtask

  task automatic testNoConfig();
    logic [31:0] v;
    int base;
    doReset();
    configure(32'h3, 32'd10, 32'd0, 32'd0);
    base = pulseCount;
    wr(8'h28, ARM1); wr(8'h28, ARM2);
    repeat (30) @(negedge clk);
    check("R5 no pulse without mode", pulseCount - base, 0);
    rd(8'h10, v); check("R5 count frozen", v, 0);
    rd(8'h28, v); check("R5 still armed", v, 32'h4000);
  endtask

  task automatic testService();
    logic [31:0] v;
    int base;
    doReset();
    configure(32'hB, 32'd60, 32'd0, 32'd0);
    base = pulseCount;
    wr(8'h28, ARM1); wr(8'h28, ARM2);
    repeat (40) @(negedge clk);
    wr(8'h28, SVC1); wr(8'h28, SVC2);
    rd(8'h10, v); check("R8 count cleared", v < 32'd8, 1);
    repeat (40) @(negedge clk);
    check("R8 no timeout after service", pulseCount - base, 0);
    waitPulse(base, 200);
    check("R8 timeout later", pulseCount - base, 1);
  endtask

  task automatic testBadKeys();
    logic [31:0] v;
    int base;
    doReset();
    configure(32'hB, 32'd1000, 32'd0, 32'd0);
    base = pulseCount;
    wr(8'h28, ARM1);
    wr(8'h28, 32'h1234_4000);
    @(negedge clk);
    check("R9 prearm bad key pulse", pulseCount - base, 1);
    wr(8'h28, ARM2);
    wr(8'h28, 32'h0000_4000);
    @(negedge clk);
    check("R9 active bad key pulse", pulseCount - base, 2);
    rd(8'h28, v); check("R9 flag clear state kept", v, 32'h4000);
    wr(8'h24, 32'h0); rd(8'h24, v); check("R4 global locked", v, 32'hB);
    wr(8'h20, 32'h0); rd(8'h20, v); check("R4 timer locked", v, 32'h80);
    rd(8'h10, v); check("R9 count still running", v != 0, 1);
  endtask

  initial begin
    testResetState();
    testIdleWrites();
    testIdleKeys();
    testTimeoutExact();
    testCarry();
    testNoConfig();
    testService();
    testBadKeys();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule